// File: doc/BRIEF.md
# Two-Stage Correction-Free BCD Digit Adder

This block adds two decimal digits, each held as a 4-bit binary-coded decimal value, together with a one-bit decimal carry-in. It returns one BCD sum digit and a decimal carry-out, so the 5-bit result {carry_out, sum_digit} is the BCD form of the total from 0 to 19. It is the building cell for wider decimal adders. Those adders chain several instances through carry_out and carry_in, but the chaining is outside this block.

The logic never forms a full binary sum that is then fixed up by adding six. A low stage looks only at the two low bits of each operand and the carry-in. It yields the final sum bit 0 and a 2-bit partial value. A high stage combines that partial value with the two upper bits of each operand. It yields sum bits 3 to 1 and the carry-out. Each stage output depends on at most six inputs, so each maps onto one six-input lookup table.

A parameter selects either a registered output, the default, or a purely combinational path. In the registered case the result appears one clock after the operands are sampled, and an active-low asynchronous reset clears it. Operand values above 9 are outside the contract, and the result for them is unspecified.

Top module: `bcd_digit_adder`

## Requirements
- R1: For every pair of operands in 0..9 and either carry-in value, {carry_out, sum_digit} equals the BCD encoding of a_digit + b_digit + carry_in. Here sum_digit is the total modulo 10.
- R2: For operands in 0..9, sum_digit is never above 9.
- R3: Bit 0 of sum_digit equals a_digit[0] XOR b_digit[0] XOR carry_in.
- R4: carry_out is 1 exactly when a_digit + b_digit + carry_in is 10 or more. This includes the boundary totals: 9 gives 0 and 10 gives 1.
- R5: With OUT_REG = 1, the result of the operands sampled at a rising clock edge appears after that edge. It stays unchanged until the next rising edge, even if the operands change in between.
- R6: While rst_n is low, sum_digit and carry_out are 0 from the first clock edge onward.
- R7: The following fixed cases hold:
  - 6 + 8 with carry-in 0 gives carry_out 1 and sum_digit 0100.
  - 9 + 9 with carry-in 1 gives carry_out 1 and sum_digit 1001.
  - 6 + 7 with carry-in 0 gives carry_out 1 and sum_digit 0011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a_digit | input | 4 | First BCD operand, 0..9 |
| b_digit | input | 4 | Second BCD operand, 0..9 |
| carry_in | input | 1 | Decimal carry into the digit |
| sum_digit | output | 4 | BCD sum digit |
| carry_out | output | 1 | Decimal carry out of the digit |

## Verification
Every clock cycle, the assertions compare the registered result against the operands of the previous edge. They check the BCD value, the range of the sum digit, the parity of bit 0 and the carry threshold, and they also check that outputs are held at zero under reset. Only the bench's scenarios can show the following:
- every one of the 200 legal operand and carry combinations has actually been driven;
- the fixed example cases;
- the totals on each side of the carry threshold;
- the result does not move when the operands change between clock edges.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_W = 4;
    localparam int LO_W    = 2;
    localparam int HI_W    = DIGIT_W - LO_W;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        logic   cout;
        digit_t sum;
    } bcd_res_t;
endpackage

// File: rtl/bcd_lo_stage.sv
module bcd_lo_stage
    import bcd_pkg::*;
(
    input  logic [LO_W-1:0] a_lo,
    input  logic [LO_W-1:0] b_lo,
    input  logic            cin,
    output logic            s0,
    output logic [1:0]      xpart
);
    logic [LO_W:0] t;

    always_comb begin
        t     = {1'b0, a_lo} + {1'b0, b_lo} + {{LO_W{1'b0}}, cin};
        s0    = t[0];
        xpart = t[LO_W:1];
    end
endmodule

// File: rtl/bcd_hi_stage.sv
module bcd_hi_stage
    import bcd_pkg::*;
(
    input  logic [HI_W-1:0] a_hi,
    input  logic [HI_W-1:0] b_hi,
    input  logic [1:0]      xpart,
    output logic [2:0]      s_hi,
    output logic            cout
);
    logic [HI_W:0] hsum;
    logic [3:0]    h;

    always_comb begin
        hsum = {1'b0, a_hi} + {1'b0, b_hi};
        h    = {2'b00, xpart} + {hsum, 1'b0};
        cout = (h >= 4'd5);
        s_hi = cout ? 3'(h - 4'd5) : h[2:0];
    end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
    import bcd_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   a_digit,
    input  logic [3:0]   b_digit,
    input  logic         carry_in,
    output logic [3:0]   sum_digit,
    output logic         carry_out
);
    logic       s0;
    logic [1:0] xpart;
    logic [2:0] s_hi;
    logic       c_hi;
    bcd_res_t   res_c;

    bcd_lo_stage lo_i (
        .a_lo  (a_digit[LO_W-1:0]),
        .b_lo  (b_digit[LO_W-1:0]),
        .cin   (carry_in),
        .s0    (s0),
        .xpart (xpart)
    );

    bcd_hi_stage hi_i (
        .a_hi  (a_digit[DIGIT_W-1:LO_W]),
        .b_hi  (b_digit[DIGIT_W-1:LO_W]),
        .xpart (xpart),
        .s_hi  (s_hi),
        .cout  (c_hi)
    );

    always_comb begin
        res_c.cout = c_hi;
        res_c.sum  = {s_hi, s0};
    end

    generate
        if (OUT_REG) begin : g_reg
            bcd_res_t res_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_c;
            end
            assign sum_digit = res_q.sum;
            assign carry_out = res_q.cout;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign sum_digit  = res_c.sum;
            assign carry_out  = res_c.cout;
        end
    endgenerate
endmodule

// File: rtl/bcd_digit_adder_chk.sv
module bcd_digit_adder_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] a_digit,
    input logic [3:0] b_digit,
    input logic       carry_in,
    input logic [3:0] sum_digit,
    input logic       carry_out
);
    logic [4:0] tot;
    logic       ok_in;
    logic       ref_c;
    logic [3:0] ref_s;
    logic       lsb_ref;
    logic       seen_edge = 1'b0;

    always_comb begin
        tot     = {1'b0, a_digit} + {1'b0, b_digit} + {4'b0, carry_in};
        ok_in   = (a_digit <= 4'd9) && (b_digit <= 4'd9);
        ref_c   = (tot >= 5'd10);
        ref_s   = ref_c ? 4'(tot - 5'd10) : tot[3:0];
        lsb_ref = a_digit[0] ^ b_digit[0] ^ carry_in;
    end

    always @(posedge clk) seen_edge <= 1'b1;

    generate
        if (OUT_REG) begin : g_seq
            AST_SUM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(ok_in)) |->
                    (sum_digit == $past(ref_s) && carry_out == $past(ref_c))); // R1
            AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(ok_in)) |-> (sum_digit <= 4'd9)); // R2
            AST_LSB_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (sum_digit[0] == $past(lsb_ref))); // R3
            AST_CARRY_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(ok_in)) |->
                    (carry_out == ($past(tot) >= 5'd10))); // R4
            AST_RESET_ZERO: assert property (@(posedge clk)
                (seen_edge && !$past(rst_n)) |-> (sum_digit == 4'd0 && !carry_out)); // R6
        end else begin : g_cmb
            AST_SUM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
                ok_in |-> (sum_digit == ref_s && carry_out == ref_c)); // R1
            AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                ok_in |-> (sum_digit <= 4'd9)); // R2
            AST_LSB_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
                sum_digit[0] == lsb_ref); // R3
            AST_CARRY_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
                ok_in |-> (carry_out == (tot >= 5'd10))); // R4
        end
    endgenerate
endmodule

bind bcd_digit_adder bcd_digit_adder_chk #(.OUT_REG(OUT_REG)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_digit   (a_digit),
    .b_digit   (b_digit),
    .carry_in  (carry_in),
    .sum_digit (sum_digit),
    .carry_out (carry_out)
);

// File: tb/bcd_digit_adder_tb_top.sv
`timescale 1ns/1ps
module bcd_digit_adder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a_digit = 4'd0;
    logic [3:0] b_digit = 4'd0;
    logic       carry_in = 1'b0;
    logic [3:0] sum_digit;
    logic       carry_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bcd_digit_adder #(.OUT_REG(1'b1)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_digit   (a_digit),
        .b_digit   (b_digit),
        .carry_in  (carry_in),
        .sum_digit (sum_digit),
        .carry_out (carry_out)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] bcd_ref(input int a, input int b, input int c);
        int t;
        t = a + b + c;
        return {t >= 10 ? 1'b1 : 1'b0, 4'(t % 10)};
    endfunction

    task automatic drive(input int a, input int b, input int c);
        @(negedge clk);
        a_digit  = 4'(a);
        b_digit  = 4'(b);
        carry_in = 1'(c);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        a_digit = 4'd9; b_digit = 4'd9; carry_in = 1'b1;
        @(negedge clk);
        check("R6 reset", {carry_out, sum_digit}, 5'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first after reset", {carry_out, sum_digit}, 5'b11001);
    endtask

    task automatic t_examples();
        drive(6, 8, 0); check("R7 6+8", {carry_out, sum_digit}, 5'b10100);
        drive(9, 9, 1); check("R7 9+9+1", {carry_out, sum_digit}, 5'b11001);
        drive(6, 7, 0); check("R7 6+7", {carry_out, sum_digit}, 5'b10011);
    endtask

    task automatic t_boundary();
        drive(9, 0, 0); check("R4 total 9", {carry_out, sum_digit}, 5'b01001);
        drive(9, 0, 1); check("R4 total 10", {carry_out, sum_digit}, 5'b10000);
        drive(5, 4, 1); check("R4 5+4+1", {carry_out, sum_digit}, 5'b10000);
        drive(4, 5, 0); check("R4 4+5", {carry_out, sum_digit}, 5'b01001);
        drive(0, 0, 0); check("R2 zero", {carry_out, sum_digit}, 5'b00000);
    endtask

    task automatic t_hold();
        drive(1, 1, 0);
        check("R5 new value", {carry_out, sum_digit}, 5'b00010);
        a_digit = 4'd3; b_digit = 4'd4; carry_in = 1'b0;
        #2;
        check("R5 held before edge", {carry_out, sum_digit}, 5'b00010);
        @(negedge clk);
        check("R5 after edge", {carry_out, sum_digit}, 5'b00111);
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++)
                for (int c = 0; c < 2; c++) begin
                    logic [4:0] e;
                    drive(a, b, c);
                    e = bcd_ref(a, b, c);
                    check("R1 sweep", {carry_out, sum_digit}, e);
                    check("R3 lsb", {4'b0, sum_digit[0]}, {4'b0, 1'(a ^ b ^ c)});
                    if (sum_digit > 4'd9) check("R2 range", {1'b0, sum_digit}, 5'd9);
                end
    endtask

    initial begin
        t_reset();
        t_examples();
        t_boundary();
        t_hold();
        t_sweep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule